// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detect Filter

This block decides whether each of two phase-locked loops is locked. The decision uses the timing of the loop's reference pulse and feedback pulse. Both pulses are already synchronous to a fast sampling clock, and the phase error is counted in ticks of that clock.

On every rising edge of the reference, the block makes one comparison. The comparison is good when a feedback rising edge lies strictly closer than the active threshold on either side of the reference edge. Otherwise it is bad. The block runs a three-state machine per loop with the states `L_OFF`, `L_SEARCH` and `L_LOCKED`:

- `L_OFF` to `L_SEARCH`: taken when power-down is released.
- `L_SEARCH` to `L_LOCKED`: taken on the fifth consecutive good comparison, judged against the narrow threshold.
- `L_LOCKED` to `L_SEARCH`: taken on a single bad comparison, judged against the wide threshold.
- Any state to `L_OFF`: taken while power-down is high.

Each loop also has a phase meter with two states:

- `M_IDLE`: waits for a reference edge. If a feedback edge came recently enough, the comparison is decided at once.
- `M_WAIT`: entered from `M_IDLE` when no recent feedback edge exists. It counts ticks after the reference edge until a feedback edge arrives or the threshold is reached.

Software supplies the two thresholds; the wide one is normally twice the narrow one. The per-loop lock levels drive a lock indicator, and a combined flag reports that both loops are locked.

Top module: `pll_lockdet_filter`

## Requirements
- R1: A comparison is good when the nearest feedback rising edge lies fewer than THR ticks from the reference rising edge. Distances are counted in sampling-clock ticks, and the edge may come before or after. A distance equal to THR is bad. THR is `narrow_ticks` unless the loop is locked, and `wide_ticks` while it is locked.
- R2: In `L_SEARCH`, five consecutive good comparisons move the loop to `L_LOCKED`. Its bit of `lock_loop` goes high on the clock edge after the one that registers the fifth good comparison.
- R3: In `L_SEARCH`, a bad comparison clears the count of consecutive good comparisons to zero.
- R4: In `L_LOCKED`, comparisons with an error below `wide_ticks` keep the lock, even when the error is at or above `narrow_ticks`. Such errors never count toward lock while searching.
- R5: In `L_LOCKED`, a single bad comparison returns the loop to `L_SEARCH`, and its lock bit falls on the following clock edge.
- R6: A reference edge with no feedback edge inside the window, and no new feedback edge before the window expires, is a bad comparison.
- R7: While a loop's `pwr_dn` bit is high, its lock bit is low from the next clock edge and its good count is cleared. After release, five new good comparisons are required.
- R8: `lock_all` is high exactly when both loop lock bits are high.
- R9: During and immediately after reset, all lock outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick is the unit of phase error |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | NUM_LOOPS | Reference pulse per loop; the rising edge is used |
| fb_pulse | input | NUM_LOOPS | Feedback pulse per loop; the rising edge is used |
| pwr_dn | input | NUM_LOOPS | Power-down per loop; forces that loop unlocked |
| narrow_ticks | input | TW | Entry threshold in ticks |
| wide_ticks | input | TW | Exit threshold in ticks |
| lock_loop | output | NUM_LOOPS | Filtered lock level per loop |
| lock_all | output | 1 | AND of both loop lock levels |

## Verification
On every cycle, the assertions check the following:

- A comparison is never judged good and bad at once.
- Lock only rises after a good comparison made while powered up.
- Lock only falls after a bad comparison or a power-down.
- Power-down always clears lock on the next edge.

Only the bench scenarios can show that the count of five is exact and that a bad comparison restarts it. They also show that the threshold really widens once locked (hysteresis), that errors of exactly the threshold on the lead and lag sides are rejected, and that a missing feedback edge drops lock.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Phase meter: idle until a reference edge, or waiting for a lagging feedback edge
    typedef enum logic [0:0] {
        M_IDLE,
        M_WAIT
    } meter_state_t;

    // Lock filter states
    typedef enum logic [1:0] {
        L_OFF,
        L_SEARCH,
        L_LOCKED
    } lock_state_t;

endpackage

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
    import lockdet_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic          fb_in,
    input  logic          pwr_dn,
    input  logic [TW-1:0] thr,
    output logic          good,
    output logic          bad
);

    localparam logic [TW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] CNT_ONE = TW'(1);

    meter_state_t  state, nxt;
    logic          ref_q, fb_q;
    logic          ref_rise, fb_rise;
    logic [TW-1:0] fb_age;      // ticks since last feedback edge, saturating
    logic [TW-1:0] lag, lag_nxt; // ticks since the pending reference edge
    logic [TW-1:0] lead;
    logic          good_raw, bad_raw;

    assign ref_rise = ref_in & ~ref_q;
    assign fb_rise  = fb_in & ~fb_q;
    assign lead     = fb_rise ? '0 : fb_age;

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= M_IDLE;
            ref_q  <= 1'b0;
            fb_q   <= 1'b0;
            fb_age <= CNT_MAX;
            lag    <= '0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
            if (pwr_dn) begin
                state  <= M_IDLE;
                fb_age <= CNT_MAX;
                lag    <= '0;
            end else begin
                state <= nxt;
                lag   <= lag_nxt;
                if (fb_rise)
                    fb_age <= CNT_ONE;
                else if (fb_age != CNT_MAX)
                    fb_age <= fb_age + CNT_ONE;
            end
        end
    end

    // Next state and verdicts
    always_comb begin
        nxt      = state;
        lag_nxt  = lag;
        good_raw = 1'b0;
        bad_raw  = 1'b0;
        unique case (state)
            M_IDLE: begin
                if (ref_rise) begin
                    if (lead < thr) begin
                        good_raw = 1'b1;
                    end else begin
                        nxt     = M_WAIT;
                        lag_nxt = CNT_ONE;
                    end
                end
            end
            M_WAIT: begin
                if (fb_rise) begin
                    if (lag < thr) good_raw = 1'b1;
                    else           bad_raw  = 1'b1;
                    nxt = M_IDLE;
                end else if (ref_rise) begin
                    bad_raw = 1'b1;
                    lag_nxt = CNT_ONE;
                end else if (lag >= thr) begin
                    bad_raw = 1'b1;
                    nxt     = M_IDLE;
                end else begin
                    lag_nxt = lag + CNT_ONE;
                end
            end
            default: nxt = M_IDLE;
        endcase
    end

    assign good = good_raw & ~pwr_dn;
    assign bad  = bad_raw & ~pwr_dn;

endmodule

// File: rtl/lockdet_hysteresis.sv
module lockdet_hysteresis
    import lockdet_pkg::*;
#(
    parameter int GOOD_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic good,
    input  logic bad,
    output logic locked
);

    localparam int            CW       = $clog2(GOOD_RUN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(GOOD_RUN - 1);

    lock_state_t   state, nxt;
    logic [CW-1:0] run_cnt, run_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= L_OFF;
            run_cnt <= '0;
        end else begin
            state   <= nxt;
            run_cnt <= run_nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt     = state;
        run_nxt = run_cnt;
        if (pwr_dn) begin
            nxt     = L_OFF;
            run_nxt = '0;
        end else begin
            unique case (state)
                L_OFF: begin
                    nxt     = L_SEARCH;
                    run_nxt = '0;
                end
                L_SEARCH: begin
                    if (bad) begin
                        run_nxt = '0;
                    end else if (good) begin
                        if (run_cnt == RUN_LAST) begin
                            nxt     = L_LOCKED;
                            run_nxt = '0;
                        end else begin
                            run_nxt = run_cnt + CW'(1);
                        end
                    end
                end
                L_LOCKED: begin
                    if (bad) nxt = L_SEARCH;
                end
                default: nxt = L_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        locked = (state == L_LOCKED);
    end

endmodule

// File: rtl/pll_lockdet_filter.sv
module pll_lockdet_filter #(
    parameter int NUM_LOOPS = 2,
    parameter int TW        = 8,
    parameter int GOOD_RUN  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOOPS-1:0] ref_pulse,
    input  logic [NUM_LOOPS-1:0] fb_pulse,
    input  logic [NUM_LOOPS-1:0] pwr_dn,
    input  logic [TW-1:0]        narrow_ticks,
    input  logic [TW-1:0]        wide_ticks,
    output logic [NUM_LOOPS-1:0] lock_loop,
    output logic                 lock_all
);

    logic [NUM_LOOPS-1:0] good_v;
    logic [NUM_LOOPS-1:0] bad_v;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        logic [TW-1:0] thr;
        assign thr = lock_loop[g] ? wide_ticks : narrow_ticks;

        lockdet_phase_meter #(.TW(TW)) i_meter (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_in (ref_pulse[g]),
            .fb_in  (fb_pulse[g]),
            .pwr_dn (pwr_dn[g]),
            .thr    (thr),
            .good   (good_v[g]),
            .bad    (bad_v[g])
        );

        lockdet_hysteresis #(.GOOD_RUN(GOOD_RUN)) i_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_dn (pwr_dn[g]),
            .good   (good_v[g]),
            .bad    (bad_v[g]),
            .locked (lock_loop[g])
        );
    end

    assign lock_all = &lock_loop;

endmodule

// File: rtl/pll_lockdet_filter_chk.sv
module pll_lockdet_filter_chk #(
    parameter int NUM_LOOPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LOOPS-1:0] pwr_dn,
    input logic [NUM_LOOPS-1:0] lock_loop,
    input logic [NUM_LOOPS-1:0] good_v,
    input logic [NUM_LOOPS-1:0] bad_v
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_low_r9: assert (lock_loop == '0);
        end
    end

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
        p_verdict_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(good_v[g] && bad_v[g]));

        p_rise_after_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_loop[g]) |-> ($past(good_v[g]) && !$past(pwr_dn[g])));

        p_fall_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lock_loop[g]) |-> ($past(bad_v[g]) || $past(pwr_dn[g])));

        p_pd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_dn[g] |=> !lock_loop[g]);
    end

endmodule

bind pll_lockdet_filter pll_lockdet_filter_chk #(.NUM_LOOPS(NUM_LOOPS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .lock_loop (lock_loop),
    .good_v    (good_v),
    .bad_v     (bad_v)
);

// File: tb/test_pll_lockdet_filter.sv
module test_pll_lockdet_filter;

    localparam int PER     = 40;
    localparam int REF_POS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_pulse = '0;
    logic [1:0] fb_pulse = '0;
    logic [1:0] pwr_dn = '0;
    logic [7:0] narrow_ticks = 8'd4;
    logic [7:0] wide_ticks = 8'd8;
    logic [1:0] lock_loop;
    logic       lock_all;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pll_lockdet_filter i_pll_lockdet_filter (
        .clk, .rst_n, .ref_pulse, .fb_pulse, .pwr_dn,
        .narrow_ticks, .wide_ticks, .lock_loop, .lock_all
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // n reference periods on the loops in mask; feedback at offset off (ticks)
    task automatic run_periods(input logic [1:0] mask, input int n, input int off, input bit fb_on);
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i < PER; i++) begin
                @(negedge clk);
                ref_pulse = (i == REF_POS) ? mask : 2'b00;
                fb_pulse  = (fb_on && i == REF_POS + off) ? mask : 2'b00;
            end
        end
    endtask

    task automatic t_reset;
        check("R9 lock_loop after reset", lock_loop[0] | lock_loop[1], 1'b0);
        check("R9 lock_all after reset", lock_all, 1'b0);
    endtask

    task automatic t_entry;
        run_periods(2'b01, 4, 0, 1);
        check("R2 four good not locked", lock_loop[0], 1'b0);
        run_periods(2'b01, 1, 0, 1);
        check("R2 fifth good locks", lock_loop[0], 1'b1);
        check("R8 lock_all with one loop", lock_all, 1'b0);
    endtask

    task automatic t_combined;
        run_periods(2'b10, 5, 2, 1);
        check("R2 loop1 locks", lock_loop[1], 1'b1);
        check("R8 lock_all both locked", lock_all, 1'b1);
    endtask

    task automatic t_wide;
        run_periods(2'b11, 3, 6, 1);
        check("R4 lag 6 keeps lock", lock_loop[0] & lock_loop[1], 1'b1);
        run_periods(2'b11, 1, -7, 1);
        check("R4 R1 lead 7 keeps lock", lock_loop[0] & lock_loop[1], 1'b1);
    endtask

    task automatic t_drop;
        run_periods(2'b01, 1, 8, 1);
        check("R5 lag equal wide drops", lock_loop[0], 1'b0);
        check("R5 other loop kept", lock_loop[1], 1'b1);
        check("R8 lock_all after drop", lock_all, 1'b0);
    endtask

    task automatic t_hyst;
        run_periods(2'b01, 6, 6, 1);
        check("R4 lag 6 cannot enter", lock_loop[0], 1'b0);
    endtask

    task automatic t_lead_and_missing;
        run_periods(2'b01, 5, -3, 1);
        check("R1 lead 3 locks", lock_loop[0], 1'b1);
        run_periods(2'b01, 1, 0, 0);
        check("R6 missing feedback drops", lock_loop[0], 1'b0);
    endtask

    task automatic t_run_reset;
        run_periods(2'b01, 4, 3, 1);
        run_periods(2'b01, 1, -4, 1);
        run_periods(2'b01, 4, 3, 1);
        check("R3 lead 4 bad restarts count", lock_loop[0], 1'b0);
        run_periods(2'b01, 1, 4, 1);
        run_periods(2'b01, 4, 3, 1);
        check("R3 R1 lag 4 bad restarts count", lock_loop[0], 1'b0);
        run_periods(2'b01, 1, 3, 1);
        check("R3 fresh run of five locks", lock_loop[0], 1'b1);
    endtask

    task automatic t_power_down;
        @(negedge clk);
        pwr_dn = 2'b01;
        @(negedge clk);
        check("R7 power-down clears lock", lock_loop[0], 1'b0);
        run_periods(2'b01, 5, 0, 1);
        check("R7 no lock while powered down", lock_loop[0], 1'b0);
        check("R7 other loop unaffected", lock_loop[1], 1'b1);
        pwr_dn = 2'b00;
        run_periods(2'b01, 4, 0, 1);
        check("R7 four after release not locked", lock_loop[0], 1'b0);
        run_periods(2'b01, 1, 0, 1);
        check("R7 five after release locks", lock_loop[0], 1'b1);
        check("R8 lock_all restored", lock_all, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_entry();
        t_combined();
        t_wide();
        t_drop();
        t_hyst();
        t_lead_and_missing();
        t_run_reset();
        t_power_down();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule